// File: doc/BRIEF.md
# Mode-Switchable Serial Receive Queue

This block is the receive byte queue of a 16550-style serial port register model. Bytes come in from an external receive source or, while the port is in loopback mode, from the port's own transmit path. They leave one at a time when the host reads the data register. The head byte is always presented on `pop_data`, and a pop removes it.

The queue has two capacities, picked at run time by the enable bit of an 8-bit FIFO control register held inside the block. With the bit clear, as after reset, the queue holds a single byte, like the legacy single holding buffer. With the bit set it holds `DEPTH` bytes (16 by default). Any write that flips the enable bit empties the queue. The receiver-reset bit also empties it when FIFO mode stays on. The DMA-mode and receive-trigger bits are only stored and read back.

A full queue turns away further bytes. A byte turned away while loopback is active produces a one-cycle overrun pulse. The block also reports its fill level and whether it holds any data.

Top module: `sio_rxq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `ctl_rdata` is 0, capacity is 1, `level` is 0, `not_empty` is 0, `push_ready` is 1 and `overrun` is 0.
- R2: A control write whose bit 0 (enable) is 0 stores 0, and all other written bits are ignored. A control write whose bit 0 is 1 stores only bits 0, 3, 6 and 7 of the written value, which is the value ANDed with 0xC9. `ctl_rdata` shows the stored value from the next cycle on.
- R3: A control write that changes bit 0 empties the queue (`level` 0 in the next cycle). The capacity becomes `DEPTH` if bit 0 is now 1 and 1 if it is now 0.
- R4: A control write with bit 0 = 1 and bit 1 (receiver reset) = 1 empties the queue and leaves the capacity at `DEPTH`. In any cycle where a control write empties the queue, that cycle's push and pop are discarded and no overrun is reported.
- R5: A push is accepted when `level` is below the current capacity. Bytes leave in the order they were accepted. `pop_data` shows the oldest byte, and `pop_req` removes it at the clock edge.
- R6: `push_ready` is 0 exactly when `level` equals the current capacity. After a pop from a full queue it is 1 again in the next cycle.
- R7: A push offered while the queue is full is rejected, and the queue contents are unchanged. If that push comes from the loopback input while `loop_en` is 1, `overrun` is 1 for exactly the next cycle. A rejected external push raises no overrun.
- R8: While `loop_en` is 1, bytes offered on the external input are consumed and discarded, and only `lb_valid`/`lb_data` feed the queue. While `loop_en` is 0, the loopback input is ignored.
- R9: A pop from an empty queue changes nothing, and `pop_data` reads 0xFF whenever the queue is empty.
- R10: Read and write positions wrap at the current capacity. Sustained traffic that passes through the storage many times keeps strict first-in, first-out order in both modes.
- R11: A push and a pop in the same cycle on a queue that is neither full nor empty leave `level` unchanged. On a full queue the push is rejected and the pop is taken. On an empty queue the pop is ignored and the push is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | FIFO control register write strobe |
| ctl_wdata | input | 8 | FIFO control register write value |
| ctl_rdata | output | 8 | Stored FIFO control value |
| loop_en | input | 1 | Loopback mode active |
| ext_valid | input | 1 | External receive byte offered |
| ext_data | input | 8 | External receive byte |
| lb_valid | input | 1 | Loopback byte offered |
| lb_data | input | 8 | Loopback byte |
| push_ready | output | 1 | Queue can accept a byte (not full) |
| pop_req | input | 1 | Host data-register read: remove head byte |
| pop_data | output | 8 | Head byte, or 0xFF when empty |
| level | output | $clog2(DEPTH+1) | Number of bytes held |
| not_empty | output | 1 | Queue holds at least one byte |
| overrun | output | 1 | One-cycle pulse: loopback byte lost to a full queue |

## Verification
The hardest state to reach is a full queue in FIFO mode after the positions have wrapped, with a loopback byte arriving in the same cycle as a pop or a control write. To get there, the stimulus fills the queue, drains part of it and refills it past the storage end, then switches loopback on and pushes into the full queue. It then mixes in control writes that do and do not flip the enable bit. A long random phase with rare control writes and rare loopback toggles then pushes the queue through mode changes at arbitrary fill levels. On every clock, a behavioural queue model predicts every output.

// File: rtl/sio_rxq_pkg.sv
// Package: shared constants for the mode-switchable receive queue.
// The control-register bit positions are decoded by the host-side register model,
// so they are fixed; everything else derives from them.
package sio_rxq_pkg;
    localparam int CTL_W     = 8;
    localparam int EN_BIT    = 0;   // FIFO mode enable
    localparam int RXRST_BIT = 1;   // receiver reset request
    localparam int DMA_BIT   = 3;   // DMA mode select, stored only
    localparam int TRIG_LO   = 6;   // receive trigger level, stored only
    localparam int TRIG_HI   = 7;
    localparam logic [CTL_W-1:0] KEEP_MASK =
        CTL_W'((1 << EN_BIT) | (1 << DMA_BIT) | (1 << TRIG_LO) | (1 << TRIG_HI));

    // Which input currently feeds the queue
    typedef enum logic {SRC_EXT = 1'b0, SRC_LOOP = 1'b1} src_sel_e;
endpackage

// File: rtl/sio_rxq_ctl.sv
// Module: FIFO control register.
// Holds the stored control value and decodes, for each write, whether the queue
// must be emptied. It also derives the queue capacity (1 or DEPTH) from the stored
// enable bit.
// Assumes: a write and its flush take effect at the same clock edge.
module sio_rxq_ctl
    import sio_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output logic             flush,
    output logic [CNT_W-1:0] cap
);
    logic [CTL_W-1:0] ctl_q;
    logic             en_flip;

    // Decode the flush request of the current write
    always_comb begin
        en_flip = wr & (wdata[EN_BIT] ^ ctl_q[EN_BIT]);
        flush   = en_flip | (wr & wdata[EN_BIT] & wdata[RXRST_BIT]);
    end

    // Store the control value: all zero when disabled, masked when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q <= wdata[EN_BIT] ? (wdata & KEEP_MASK) : '0;
        end
    end

    // Capacity follows the stored enable bit
    always_comb cap = ctl_q[EN_BIT] ? CNT_W'(DEPTH) : CNT_W'(1);

    assign rdata = ctl_q;
endmodule

// File: rtl/sio_rxq_src.sv
// Module: push source selection and overrun detection.
// Chooses the loopback or external input by mode and qualifies the push with
// full/flush. It registers a one-cycle overrun pulse when a loopback byte meets
// a full queue.
// Assumes: external bytes in loopback mode are consumed and dropped.
module sio_rxq_src
    import sio_rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              ext_valid,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              lb_valid,
    input  logic [DATA_W-1:0] lb_data,
    input  logic              full,
    input  logic              flush,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              overrun
);
    src_sel_e src_sel;
    logic     sel_valid;
    logic     ovr_d;

    // Pick the active source and gate the push
    always_comb begin
        src_sel = loop_en ? SRC_LOOP : SRC_EXT;
        case (src_sel)
            SRC_LOOP: begin
                sel_valid = lb_valid;
                push_data = lb_data;
            end
            default: begin
                sel_valid = ext_valid;
                push_data = ext_data;
            end
        endcase
        push  = sel_valid & ~full & ~flush;
        ovr_d = (src_sel == SRC_LOOP) & lb_valid & full & ~flush;
    end

    // Register the overrun pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else begin
            overrun <= ovr_d;
        end
    end
endmodule

// File: rtl/sio_rxq_store.sv
// Module: circular byte storage with a run-time capacity.
// Holds DEPTH entries, but the read and write positions wrap at the cap input,
// which may be smaller. A flush clears the positions and the count and
// overrides any push or pop in the same cycle.
// Assumes: the caller only asserts push when not full; pop on empty is ignored here.
module sio_rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [CNT_W-1:0]  cap,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              pop_ok;

    // Advance a position, wrapping at the current capacity
    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] nxt;
        nxt = CNT_W'(p) + CNT_W'(1);
        return (nxt >= c) ? '0 : PTR_W'(nxt);
    endfunction

    // Status flags
    always_comb begin
        empty  = (count == '0);
        full   = (count == cap);
        pop_ok = pop & ~empty & ~flush;
    end

    // Head byte, all ones when nothing is held
    always_comb rd_data = empty ? '1 : mem[rd_ptr];

    // Write the pushed byte into its slot
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && (wr_ptr == PTR_W'(i))) begin
                mem[i] <= push_data;
            end
        end
    end

    // Positions and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= step_ptr(wr_ptr, cap);
            end
            if (pop_ok) begin
                rd_ptr <= step_ptr(rd_ptr, cap);
            end
            case ({push, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sio_rxq.sv
// Module: mode-switchable serial receive queue (top).
// Joins the control register, the source selector and the storage. Capacity is 1
// while the stored enable bit is clear and DEPTH while it is set.
// Assumes: a single clock domain; all inputs are synchronous to clk.
module sio_rxq
    import sio_rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_wr,
    input  logic [7:0]                 ctl_wdata,
    output logic [7:0]                 ctl_rdata,
    input  logic                       loop_en,
    input  logic                       ext_valid,
    input  logic [DATA_W-1:0]          ext_data,
    input  logic                       lb_valid,
    input  logic [DATA_W-1:0]          lb_data,
    output logic                       push_ready,
    input  logic                       pop_req,
    output logic [DATA_W-1:0]          pop_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       not_empty,
    output logic                       overrun
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             flush;
    logic [CNT_W-1:0] cap;
    logic             full, empty, push;
    logic [DATA_W-1:0] push_data;

    sio_rxq_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .rdata (ctl_rdata),
        .flush (flush),
        .cap   (cap)
    );

    sio_rxq_src #(.DATA_W(DATA_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_en   (loop_en),
        .ext_valid (ext_valid),
        .ext_data  (ext_data),
        .lb_valid  (lb_valid),
        .lb_data   (lb_data),
        .full      (full),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .overrun   (overrun)
    );

    sio_rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .cap       (cap),
        .push      (push),
        .push_data (push_data),
        .pop       (pop_req),
        .rd_data   (pop_data),
        .count     (level),
        .full      (full),
        .empty     (empty)
    );

    // Port-side status
    always_comb begin
        push_ready = ~full;
        not_empty  = ~empty;
    end
endmodule

// File: rtl/sio_rxq_chk.sv
// Module: property checker for sio_rxq, attached by bind.
// Observes only the top-level ports of the queue.
module sio_rxq_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ctl_wr,
    input logic [7:0]                 ctl_wdata,
    input logic [7:0]                 ctl_rdata,
    input logic                       loop_en,
    input logic                       ext_valid,
    input logic                       lb_valid,
    input logic                       push_ready,
    input logic                       pop_req,
    input logic [DATA_W-1:0]          pop_data,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       not_empty,
    input logic                       overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cap_c;
    logic             src_v;
    always_comb begin
        cap_c = ctl_rdata[0] ? CNT_W'(DEPTH) : CNT_W'(1);
        src_v = loop_en ? lb_valid : ext_valid;
    end

    // R6
    ready_vs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ready == (level != cap_c));

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap_c);

    // R9
    empty_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |-> (pop_data == '1));

    // R3
    mode_flip_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (ctl_wdata[0] != ctl_rdata[0])) |=> (level == '0));

    // R7
    overrun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && lb_valid && !push_ready && !ctl_wr) |=> overrun);

    // R7
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(loop_en && lb_valid && !push_ready));

    // R11
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && pop_req && src_v && not_empty && push_ready) |=> $stable(level));

    // R8
    ext_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && loop_en && ext_valid && !lb_valid && !pop_req) |=> $stable(level));
endmodule

bind sio_rxq sio_rxq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .loop_en    (loop_en),
    .ext_valid  (ext_valid),
    .lb_valid   (lb_valid),
    .push_ready (push_ready),
    .pop_req    (pop_req),
    .pop_data   (pop_data),
    .level      (level),
    .not_empty  (not_empty),
    .overrun    (overrun)
);

// File: tb/sio_rxq_bench.sv
// Bench: behavioural queue model compared with the design on every clock.
module sio_rxq_bench;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       loop_en = 1'b0;
    logic       ext_valid = 1'b0;
    logic [7:0] ext_data = '0;
    logic       lb_valid = 1'b0;
    logic [7:0] lb_data = '0;
    logic       push_ready;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic [4:0] level;
    logic       not_empty;
    logic       overrun;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // model state
    logic [7:0] mq[$];
    logic [7:0] m_ctl = '0;
    logic       m_ovr = 1'b0;

    always #10 clk = ~clk;

    sio_rxq u_sio_rxq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .loop_en(loop_en), .ext_valid(ext_valid),
        .ext_data(ext_data), .lb_valid(lb_valid), .lb_data(lb_data),
        .push_ready(push_ready), .pop_req(pop_req), .pop_data(pop_data),
        .level(level), .not_empty(not_empty), .overrun(overrun)
    );

    function automatic int m_cap();
        return m_ctl[0] ? DEPTH : 1;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("ctl_rdata", ctl_rdata, m_ctl);
        chk("level", level, mq.size());
        chk("not_empty", not_empty, mq.size() > 0);
        chk("push_ready", push_ready, mq.size() != m_cap());
        chk("pop_data", pop_data, (mq.size() > 0) ? mq[0] : 8'hFF);
        chk("overrun", overrun, m_ovr);
    endtask

    // One cycle: check present outputs, drive inputs, advance model
    task automatic step(input logic w, input logic [7:0] wd, input logic le,
                        input logic ev, input logic [7:0] ed,
                        input logic lv, input logic [7:0] ld, input logic pp);
        logic fl, full, sv;
        logic [7:0] sd;
        compare();
        ctl_wr = w; ctl_wdata = wd; loop_en = le; ext_valid = ev; ext_data = ed;
        lb_valid = lv; lb_data = ld; pop_req = pp;
        full = (mq.size() == m_cap());
        fl = 1'b0;
        if (w) begin
            fl = (wd[0] ^ m_ctl[0]) || (wd[0] && wd[1]);
            m_ctl = wd[0] ? (wd & 8'hC9) : 8'h00;
        end
        if (fl) begin
            mq.delete();
            m_ovr = 1'b0;
        end else begin
            sv = le ? lv : ev;
            sd = le ? ld : ed;
            m_ovr = le && lv && full;
            if (pp && mq.size() > 0) void'(mq.pop_front());
            if (sv && !full) mq.push_back(sd);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, loop_en, 0, 0, 0, 0, 0);
    endtask
    task automatic epush(input logic [7:0] d);
        step(0, 0, 0, 1, d, 0, 0, 0);
    endtask
    task automatic pop1();
        step(0, 0, loop_en, 0, 0, 0, 0, 1);
    endtask
    task automatic cwr(input logic [7:0] d);
        step(1, d, loop_en, 0, 0, 0, 0, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1"; idle(2);
        // R9: pops on an empty queue
        tag = "R9"; pop1(); pop1(); idle(1);
        // R5: single-entry mode push and pop
        tag = "R5"; epush(8'h11); pop1(); idle(1);
        // R6 / R7: full single entry, external push rejected, no overrun
        tag = "R6"; epush(8'h22);
        tag = "R7"; epush(8'h33); idle(1);
        // R11: push+pop on full single entry: push rejected, pop taken
        tag = "R11"; step(0, 0, 0, 1, 8'h44, 0, 0, 1);
        tag = "R11"; step(0, 0, 0, 1, 8'h55, 0, 0, 1); pop1(); idle(1);
        // R2: control writes
        tag = "R2"; cwr(8'hFE); idle(1); cwr(8'hFF); idle(1); cwr(8'h49); idle(1);
        // R10: fill, partial drain, refill past the storage end, drain
        tag = "R10";
        for (int i = 0; i < 16; i++) epush(8'(i * 7 + 1));
        epush(8'hEE);
        for (int i = 0; i < 5; i++) pop1();
        for (int i = 0; i < 5; i++) epush(8'(8'hA0 + i));
        for (int i = 0; i < 17; i++) pop1();
        // R11: simultaneous push and pop, mid occupancy
        tag = "R11";
        for (int i = 0; i < 3; i++) epush(8'(8'h30 + i));
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 8'(8'h60 + i), 0, 0, 1);
        for (int i = 0; i < 4; i++) pop1();
        // R7: loopback fill and overrun
        tag = "R7";
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, 1, 8'(8'h80 + i), 0);
        step(0, 0, 1, 0, 0, 1, 8'hF0, 0);
        step(0, 0, 1, 0, 0, 1, 8'hF1, 0);
        idle(2);
        // R6: ready back after pop from full
        tag = "R6"; pop1(); idle(1);
        // R8: external bytes dropped in loopback, loopback ignored otherwise
        tag = "R8";
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 8'h5A, 0, 0, 1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 8'hA5, 0);
        for (int i = 0; i < 14; i++) pop1();
        // R4: receiver reset with FIFO on, push/pop same cycle discarded
        tag = "R4";
        for (int i = 0; i < 4; i++) epush(8'(8'h10 + i));
        step(1, 8'h03, 0, 1, 8'h99, 0, 0, 1); idle(1); epush(8'h77); idle(1);
        // R3: clear enable with data held -> flush, capacity 1
        tag = "R3";
        for (int i = 0; i < 3; i++) epush(8'(8'h20 + i));
        cwr(8'h00); idle(1); epush(8'h01); epush(8'h02); idle(1);
        cwr(8'h01); idle(1);
        // R5: random mixed traffic with rare mode changes
        tag = "R5";
        for (int i = 0; i < 6000; i++) begin
            logic w, le;
            w  = ($urandom_range(0, 59) == 0);
            le = ($urandom_range(0, 199) == 0) ? ~loop_en : loop_en;
            step(w, 8'($urandom), le, 1'($urandom), 8'($urandom),
                 1'($urandom), 8'($urandom), ($urandom_range(0, 2) == 0));
        end
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule